// File: doc/BRIEF.md
# Streaming JSON Token Lexer

This block sits between a byte source and a JSON syntax checker. It takes the bytes of one message, one byte per valid/ready handshake, and sends out a stream of 4-bit token codes. Each code comes with the byte offset at which its token begins, so a later stage can map every byte back to the token that covers it. Matching is driven by a constant next-state table. The table is indexed by the current automaton state and by a compressed class of the input byte. The table is computed at elaboration from a package function, and the top module holds it as a ROM.

Tokens are found by longest match. When the current byte cannot extend a token that is already complete, the lexer emits that token and then scans the same byte again from the start state, so the byte is not lost. A byte that fits no token rejects the message. A message longer than the configured maximum is also rejected. After a reject the lexer swallows the rest of the message, up to the end-of-message strobe. A message that lexes cleanly ends with an end-of-message code whose offset is the message length.

Top module: `jlex_top`

## Requirements
- R1: After reset, out_valid is low, and in_ready is high for a whitespace byte offered with in_valid.
- R2: Each of the bytes `{ } [ ] : ,` yields a single-byte token with code 0, 1, 2, 3, 4, 5 respectively, at its own offset. Outputs only ever carry codes 0 to 12 or 15.
- R3: A string token (code 6) runs from one double quote to the next unescaped double quote, and its offset is that of the opening quote. It may contain printable bytes 0x20..0x7E. After a backslash, only `" \ / b f n r t` are legal. Any other escaped byte, including `u`, rejects the message.
- R4: An integer token (code 7) is an optional minus followed by either `0` or a nonzero digit and more digits. A float token (code 8) is an integer followed by a fraction (`.` and one or more digits), an exponent (`e` or `E`, an optional sign, and one or more digits), or both.
- R5: `true`, `false` and `null` yield codes 9, 10 and 11. A partial or misspelled literal rejects the message.
- R6: When a byte cannot extend a complete token, that token is emitted first. The same byte then starts the next token, so `01` gives two integers at offsets 0 and 1.
- R7: Space, tab, CR and LF between tokens are consumed and produce no token.
- R8: in_last marks the final byte of a message. Any complete pending token is emitted. Then code 12 (end of message) is emitted with the message length as its offset.
- R9: A reject emits code 15 with the offset of the first byte that could not be used, or the message length if the message ends inside a token. The remaining bytes up to in_last are taken without producing tokens, and the next message starts again at offset 0.
- R10: A byte arriving at offset MAX_LEN rejects the message with code 15 at offset MAX_LEN. A message of exactly MAX_LEN bytes is accepted.
- R11: Bytes 0x7F..0xFF, and control bytes other than tab, CR and LF, reject the message wherever they appear.
- R12: While out_valid is high and out_ready low, out_tok and out_off hold, and no byte is taken while scanning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Lexer takes the offered byte this cycle |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Offered byte is the final byte of the message |
| out_valid | output | 1 | A token code is presented |
| out_ready | input | 1 | Downstream takes the token |
| out_tok | output | 4 | Token code (0..11 tokens, 12 end of message, 15 reject) |
| out_off | output | $clog2(MAX_LEN+1) | Start offset of the token, or the position for codes 12 and 15 |

## Verification
Two events can fall in the same cycle. The first pair is a token finishing and the byte that ends it arriving: the lexer must emit the token and still keep that byte. The second pair is the last byte of a message and the flush of the token it completes. Both are provoked by sweeping every byte value as a whole message, inside a string and after a backslash, and by directed messages whose tokens abut with no whitespace and whose final token ends exactly on the in_last byte. These runs use several backpressure patterns on out_ready. Each case is judged by the complete code and offset sequence, which the bench computes from the byte values. Any extra or missing token counts as a failure.

// File: rtl/jlex_pkg.sv
package jlex_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int SW = 5;              // state code width
    localparam int CW = 5;              // byte class width
    localparam int NS = 1 << SW;        // table rows
    localparam int NC = 1 << CW;        // table columns

    typedef enum logic [3:0] {
        TK_LBRACE = 4'd0,  TK_RBRACE = 4'd1,  TK_LBRACK = 4'd2, TK_RBRACK = 4'd3,
        TK_COLON  = 4'd4,  TK_COMMA  = 4'd5,  TK_STR    = 4'd6, TK_INT    = 4'd7,
        TK_FLT    = 4'd8,  TK_TRU    = 4'd9,  TK_FLS    = 4'd10, TK_NUL   = 4'd11,
        TK_EOM    = 4'd12, TK_ERR    = 4'd15
    } tok_e;

    typedef enum logic [CW-1:0] {
        C_SP, C_CTLWS, C_LBRACE, C_RBRACE, C_LBRACK, C_RBRACK, C_COLON, C_COMMA,
        C_QUOTE, C_BSL, C_MINUS, C_PLUS, C_ZERO, C_D19, C_DOT, C_LE, C_UE,
        C_T, C_R, C_U, C_F, C_A, C_L, C_S, C_N, C_B, C_SLASH, C_PRINT, C_BAD
    } cls_e;

    typedef enum logic [SW-1:0] {
        S_START,
        S_LBRACE, S_RBRACE, S_LBRACK, S_RBRACK, S_COLON, S_COMMA,
        S_STR, S_ESC, S_STREND,
        S_MINUS, S_ZERO, S_INT, S_DOT, S_FRAC, S_EXP, S_EXPSGN, S_EXPDIG,
        S_T, S_TR, S_TRU, S_TRUE,
        S_F, S_FA, S_FAL, S_FALS, S_FALSE,
        S_N, S_NU, S_NUL, S_NULL,
        S_DEAD
    } st_e;

    typedef enum logic [1:0] {P_SCAN, P_FLUSH, P_DRAIN} phase_e;

    function automatic logic is_digit(cls_e c);
        return (c == C_ZERO) || (c == C_D19);
    endfunction

    // one entry of the transition table
    function automatic st_e next_state(st_e s, cls_e c);
        st_e n;
        n = S_DEAD;
        case (s)
            S_START: case (c)
                C_SP, C_CTLWS: n = S_START;
                C_LBRACE: n = S_LBRACE;
                C_RBRACE: n = S_RBRACE;
                C_LBRACK: n = S_LBRACK;
                C_RBRACK: n = S_RBRACK;
                C_COLON:  n = S_COLON;
                C_COMMA:  n = S_COMMA;
                C_QUOTE:  n = S_STR;
                C_MINUS:  n = S_MINUS;
                C_ZERO:   n = S_ZERO;
                C_D19:    n = S_INT;
                C_T:      n = S_T;
                C_F:      n = S_F;
                C_N:      n = S_N;
                default:  n = S_DEAD;
            endcase
            S_STR: case (c)
                C_QUOTE: n = S_STREND;
                C_BSL:   n = S_ESC;
                C_CTLWS, C_BAD: n = S_DEAD;
                default: n = S_STR;
            endcase
            S_ESC: case (c)
                C_QUOTE, C_BSL, C_SLASH, C_B, C_F, C_N, C_R, C_T: n = S_STR;
                default: n = S_DEAD;
            endcase
            S_MINUS:  if (c == C_ZERO) n = S_ZERO; else if (c == C_D19) n = S_INT;
            S_ZERO:   if (c == C_DOT) n = S_DOT; else if (c == C_LE || c == C_UE) n = S_EXP;
            S_INT: begin
                if (is_digit(c)) n = S_INT;
                else if (c == C_DOT) n = S_DOT;
                else if (c == C_LE || c == C_UE) n = S_EXP;
            end
            S_DOT:    if (is_digit(c)) n = S_FRAC;
            S_FRAC:   if (is_digit(c)) n = S_FRAC; else if (c == C_LE || c == C_UE) n = S_EXP;
            S_EXP:    if (c == C_PLUS || c == C_MINUS) n = S_EXPSGN; else if (is_digit(c)) n = S_EXPDIG;
            S_EXPSGN: if (is_digit(c)) n = S_EXPDIG;
            S_EXPDIG: if (is_digit(c)) n = S_EXPDIG;
            S_T:      if (c == C_R)  n = S_TR;
            S_TR:     if (c == C_U)  n = S_TRU;
            S_TRU:    if (c == C_LE) n = S_TRUE;
            S_F:      if (c == C_A)  n = S_FA;
            S_FA:     if (c == C_L)  n = S_FAL;
            S_FAL:    if (c == C_S)  n = S_FALS;
            S_FALS:   if (c == C_LE) n = S_FALSE;
            S_N:      if (c == C_U)  n = S_NU;
            S_NU:     if (c == C_L)  n = S_NUL;
            S_NUL:    if (c == C_L)  n = S_NULL;
            default:  n = S_DEAD;
        endcase
        return n;
    endfunction

    function automatic logic is_accept(st_e s);
        case (s)
            S_LBRACE, S_RBRACE, S_LBRACK, S_RBRACK, S_COLON, S_COMMA,
            S_STREND, S_ZERO, S_INT, S_FRAC, S_EXPDIG,
            S_TRUE, S_FALSE, S_NULL: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic tok_e tok_of(st_e s);
        case (s)
            S_LBRACE: return TK_LBRACE;
            S_RBRACE: return TK_RBRACE;
            S_LBRACK: return TK_LBRACK;
            S_RBRACK: return TK_RBRACK;
            S_COLON:  return TK_COLON;
            S_COMMA:  return TK_COMMA;
            S_STREND: return TK_STR;
            S_ZERO, S_INT: return TK_INT;
            S_FRAC, S_EXPDIG: return TK_FLT;
            S_TRUE:   return TK_TRU;
            S_FALSE:  return TK_FLS;
            S_NULL:   return TK_NUL;
            default:  return TK_ERR;
        endcase
    endfunction
endpackage

// File: rtl/jlex_class.sv
module jlex_class
    import jlex_pkg::*;
(
    input  logic [7:0] byte_i,
    output cls_e       cls_o
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        if (byte_i >= 8'h31 && byte_i <= 8'h39) begin
            cls_o = C_D19;
        end else begin
            case (byte_i)
                8'h20:               cls_o = C_SP;
                8'h09, 8'h0A, 8'h0D: cls_o = C_CTLWS;
                8'h7B: cls_o = C_LBRACE;
                8'h7D: cls_o = C_RBRACE;
                8'h5B: cls_o = C_LBRACK;
                8'h5D: cls_o = C_RBRACK;
                8'h3A: cls_o = C_COLON;
                8'h2C: cls_o = C_COMMA;
                8'h22: cls_o = C_QUOTE;
                8'h5C: cls_o = C_BSL;
                8'h2D: cls_o = C_MINUS;
                8'h2B: cls_o = C_PLUS;
                8'h30: cls_o = C_ZERO;
                8'h2E: cls_o = C_DOT;
                8'h65: cls_o = C_LE;
                8'h45: cls_o = C_UE;
                8'h74: cls_o = C_T;
                8'h72: cls_o = C_R;
                8'h75: cls_o = C_U;
                8'h66: cls_o = C_F;
                8'h61: cls_o = C_A;
                8'h6C: cls_o = C_L;
                8'h73: cls_o = C_S;
                8'h6E: cls_o = C_N;
                8'h62: cls_o = C_B;
                8'h2F: cls_o = C_SLASH;
                default: cls_o = (byte_i >= 8'h21 && byte_i <= 8'h7E) ? C_PRINT : C_BAD;
            endcase
        end
    end
endmodule

// File: rtl/jlex_trans_rom.sv
module jlex_trans_rom
    import jlex_pkg::*;
(
    input  st_e  st_i,
    input  cls_e cls_i,
    output st_e  nxt_o
);
    timeunit 1ns;
    timeprecision 1ps;

    st_e table_w [NS][NC];

    for (genvar s = 0; s < NS; s++) begin : g_row
        for (genvar c = 0; c < NC; c++) begin : g_col
            assign table_w[s][c] = next_state(st_e'(SW'(s)), cls_e'(CW'(c)));
        end
    end

    assign nxt_o = table_w[st_i][cls_i];
endmodule

// File: rtl/jlex_outreg.sv
module jlex_outreg
    import jlex_pkg::*;
#(
    parameter int OFFW = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  tok_e            ld_tok,
    input  logic [OFFW-1:0] ld_off,
    input  logic            out_ready,
    output logic            out_valid,
    output tok_e            out_tok,
    output logic [OFFW-1:0] out_off
);
    timeunit 1ns;
    timeprecision 1ps;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_tok   <= TK_EOM;
            out_off   <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_tok   <= ld_tok;
            out_off   <= ld_off;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R12
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_tok) && $stable(out_off));

    // R2
    code_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_tok <= TK_EOM) || (out_tok == TK_ERR));
endmodule

// File: rtl/jlex_top.sv
module jlex_top
    import jlex_pkg::*;
#(
    parameter int  MAX_LEN = 2048,
    localparam int OFFW    = $clog2(MAX_LEN + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [7:0]      in_data,
    input  logic            in_last,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [3:0]      out_tok,
    output logic [OFFW-1:0] out_off
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [OFFW-1:0] LIMIT = OFFW'(MAX_LEN);

    phase_e          phase_q, phase_d;
    st_e             dfa_q, dfa_d;
    logic [OFFW-1:0] off_q, off_d;
    logic [OFFW-1:0] tstart_q, tstart_d;

    cls_e            cls;
    st_e             nxt;
    logic            can_go;
    logic            at_limit;
    logic            emit;
    tok_e            emit_tok;
    logic [OFFW-1:0] emit_off;
    tok_e            otok;

    jlex_class u_class (
        .byte_i (in_data),
        .cls_o  (cls)
    );

    jlex_trans_rom u_rom (
        .st_i  (dfa_q),
        .cls_i (cls),
        .nxt_o (nxt)
    );

    always_comb begin
        can_go   = !out_valid || out_ready;
        at_limit = (off_q == LIMIT);
        in_ready = 1'b0;
        emit     = 1'b0;
        emit_tok = TK_ERR;
        emit_off = off_q;
        phase_d  = phase_q;
        dfa_d    = dfa_q;
        off_d    = off_q;
        tstart_d = tstart_q;
        case (phase_q)
            P_SCAN: begin
                in_ready = can_go && !at_limit && (nxt != S_DEAD);
                if (in_valid && can_go) begin
                    if (at_limit) begin
                        emit    = 1'b1;
                        phase_d = P_DRAIN;
                        dfa_d   = S_START;
                    end else if (nxt != S_DEAD) begin
                        dfa_d = nxt;
                        off_d = off_q + 1'b1;
                        if (dfa_q == S_START && nxt != S_START) tstart_d = off_q;
                        if (in_last) phase_d = P_FLUSH;
                    end else if (is_accept(dfa_q)) begin
                        emit     = 1'b1;
                        emit_tok = tok_of(dfa_q);
                        emit_off = tstart_q;
                        dfa_d    = S_START;
                    end else begin
                        emit    = 1'b1;
                        phase_d = P_DRAIN;
                        dfa_d   = S_START;
                    end
                end
            end
            P_FLUSH: begin
                if (can_go) begin
                    emit = 1'b1;
                    if (dfa_q == S_START) begin
                        emit_tok = TK_EOM;
                        phase_d  = P_SCAN;
                        off_d    = '0;
                    end else if (is_accept(dfa_q)) begin
                        emit_tok = tok_of(dfa_q);
                        emit_off = tstart_q;
                        dfa_d    = S_START;
                    end else begin
                        phase_d = P_SCAN;
                        off_d   = '0;
                        dfa_d   = S_START;
                    end
                end
            end
            P_DRAIN: begin
                in_ready = 1'b1;
                if (in_valid && in_last) begin
                    phase_d = P_SCAN;
                    off_d   = '0;
                end
            end
            default: begin
                phase_d = P_SCAN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= P_SCAN;
            dfa_q    <= S_START;
            off_q    <= '0;
            tstart_q <= '0;
        end else begin
            phase_q  <= phase_d;
            dfa_q    <= dfa_d;
            off_q    <= off_d;
            tstart_q <= tstart_d;
        end
    end

    jlex_outreg #(.OFFW(OFFW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (emit),
        .ld_tok    (emit_tok),
        .ld_off    (emit_off),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_tok   (otok),
        .out_off   (out_off)
    );

    assign out_tok = otok;

    // R10
    off_bound_chk: assert property (@(posedge clk) disable iff (rst)
        off_q <= LIMIT);

    // R12
    stall_no_take_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q == P_SCAN && out_valid && !out_ready |-> !in_ready);

    // R9
    drain_exit_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q == P_DRAIN && in_valid && in_last |=> phase_q == P_SCAN && off_q == '0);

    // R7
    ws_idle_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q == P_SCAN && dfa_q == S_START && in_valid && in_ready
        && (cls == C_SP || cls == C_CTLWS) |=> dfa_q == S_START);

    // R8
    flush_no_take_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q == P_FLUSH |-> !in_ready);
endmodule

// File: tb/tb_jlex_top.sv
module tb_jlex_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int MAXL = 24;
    localparam int OW   = $clog2(MAXL + 1);

    localparam int T_STR = 6, T_INT = 7, T_FLT = 8, T_TRU = 9, T_FLS = 10, T_NUL = 11;
    localparam int T_LBRACE = 0, T_RBRACE = 1, T_LBRACK = 2, T_RBRACK = 3, T_COLON = 4, T_COMMA = 5;
    localparam int T_EOM = 12, T_ERR = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_data = 8'h20;
    logic          in_last = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [3:0]    out_tok;
    logic [OW-1:0] out_off;

    always #10 clk = ~clk;

    jlex_top #(.MAX_LEN(MAXL)) dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_tok(out_tok), .out_off(out_off)
    );

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    wd = 1'b0;
    int    bp_mode = 0;
    logic [7:0] tx[$];
    int    e_tok[$];
    int    e_off[$];
    string e_req[$];
    bit    hold = 1'b0;
    logic [3:0]    h_tok;
    logic [OW-1:0] h_off;

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic expect_tok(int t, int o, string req);
        e_tok.push_back(t);
        e_off.push_back(o);
        e_req.push_back(req);
    endtask

    task automatic put_str(string s);
        for (int i = 0; i < s.len(); i++) tx.push_back(s[i]);
    endtask

    task automatic step();
        int xt;
        int xo;
        string xr;
        @(negedge clk);
        cyc++;
        if (cyc > 150000) wd = 1'b1;
        case (bp_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = (cyc % 3) != 0;
            default: out_ready = (cyc % 7) < 2;
        endcase
        if (tx.size() > 0) begin
            in_valid = 1'b1;
            in_data  = tx[0];
            in_last  = (tx.size() == 1);
        end else begin
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
        #1;
        if (hold) check(out_valid && out_tok == h_tok && out_off == h_off,
                        "R12", "held token", int'(out_tok), int'(h_tok));
        hold  = out_valid && !out_ready;
        h_tok = out_tok;
        h_off = out_off;
        if (out_valid && out_ready) begin
            if (e_tok.size() == 0) begin
                check(1'b0, "R9", "unexpected token", int'(out_tok), -1);
            end else begin
                xt = e_tok.pop_front();
                xo = e_off.pop_front();
                xr = e_req.pop_front();
                check(int'(out_tok) == xt && int'(out_off) == xo, xr, "code*1000+offset",
                      int'(out_tok) * 1000 + int'(out_off), xt * 1000 + xo);
            end
        end
        if (in_valid && in_ready) void'(tx.pop_front());
    endtask

    task automatic run_msg();
        while (!wd && (tx.size() > 0 || e_tok.size() > 0)) step();
        repeat (8) step();
        e_tok.delete();
        e_off.delete();
        e_req.delete();
        tx.delete();
    endtask

    function automatic int punct_code(int b);
        case (b)
            123: return T_LBRACE;
            125: return T_RBRACE;
            91:  return T_LBRACK;
            93:  return T_RBRACK;
            58:  return T_COLON;
            44:  return T_COMMA;
            default: return -1;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
        in_valid = 1'b1;
        in_data  = 8'h20;
        #1;
        check(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);
        in_valid = 1'b0;

        // sweep: every byte as a one-byte message (R2 R4 R7 R11)
        bp_mode = 0;
        for (int b = 0; b < 256; b++) begin
            tx.push_back(8'(b));
            if (b == 32 || b == 9 || b == 10 || b == 13) begin
                expect_tok(T_EOM, 1, "R7");
            end else if (punct_code(b) >= 0) begin
                expect_tok(punct_code(b), 0, "R2");
                expect_tok(T_EOM, 1, "R8");
            end else if (b >= 48 && b <= 57) begin
                expect_tok(T_INT, 0, "R4");
                expect_tok(T_EOM, 1, "R8");
            end else if (b == 34 || b == 45 || b == 116 || b == 102 || b == 110) begin
                expect_tok(T_ERR, 1, "R9");
            end else begin
                expect_tok(T_ERR, 0, "R11");
            end
            run_msg();
        end

        // sweep: every byte inside a string (R3 R11 R6)
        bp_mode = 1;
        for (int b = 0; b < 256; b++) begin
            tx.push_back(8'h22); tx.push_back(8'(b)); tx.push_back(8'h22);
            if (b == 34) begin
                expect_tok(T_STR, 0, "R6");
                expect_tok(T_ERR, 3, "R9");
            end else if (b == 92) begin
                expect_tok(T_ERR, 3, "R3");
            end else if (b >= 32 && b <= 126) begin
                expect_tok(T_STR, 0, "R3");
                expect_tok(T_EOM, 3, "R8");
            end else begin
                expect_tok(T_ERR, 1, "R11");
            end
            run_msg();
        end

        // sweep: every byte after a backslash (R3)
        bp_mode = 2;
        for (int b = 0; b < 256; b++) begin
            tx.push_back(8'h22); tx.push_back(8'h5C); tx.push_back(8'(b)); tx.push_back(8'h22);
            if (b == 34 || b == 92 || b == 47 || b == 98 || b == 102 ||
                b == 110 || b == 114 || b == 116) begin
                expect_tok(T_STR, 0, "R3");
                expect_tok(T_EOM, 4, "R8");
            end else begin
                expect_tok(T_ERR, 2, "R3");
            end
            run_msg();
        end

        // R5: literals in an array
        bp_mode = 1;
        put_str("[true,false,null]");
        expect_tok(T_LBRACK, 0, "R2"); expect_tok(T_TRU, 1, "R5");
        expect_tok(T_COMMA, 5, "R2");  expect_tok(T_FLS, 6, "R5");
        expect_tok(T_COMMA, 11, "R2"); expect_tok(T_NUL, 12, "R5");
        expect_tok(T_RBRACK, 16, "R2"); expect_tok(T_EOM, 17, "R8");
        run_msg();

        // R4: float with fraction and signed exponent, whitespace, integer
        bp_mode = 2;
        put_str("{\"a\":-0.5e+2, \"b\" :12}");
        expect_tok(T_LBRACE, 0, "R2"); expect_tok(T_STR, 1, "R3");
        expect_tok(T_COLON, 4, "R2");  expect_tok(T_FLT, 5, "R4");
        expect_tok(T_COMMA, 12, "R2"); expect_tok(T_STR, 14, "R7");
        expect_tok(T_COLON, 18, "R7"); expect_tok(T_INT, 19, "R4");
        expect_tok(T_RBRACE, 21, "R2"); expect_tok(T_EOM, 22, "R8");
        run_msg();

        // R6: longest match splits 01 into two integers
        bp_mode = 0;
        put_str("01");
        expect_tok(T_INT, 0, "R6"); expect_tok(T_INT, 1, "R6"); expect_tok(T_EOM, 2, "R8");
        run_msg();

        // R4: exponent without fraction, uppercase E
        put_str("7E3,");
        expect_tok(T_FLT, 0, "R4"); expect_tok(T_COMMA, 3, "R6"); expect_tok(T_EOM, 4, "R8");
        run_msg();

        // R5: literal followed by junk, and a truncated literal
        put_str("truex");
        expect_tok(T_TRU, 0, "R5"); expect_tok(T_ERR, 4, "R5");
        run_msg();
        put_str("fals");
        expect_tok(T_ERR, 4, "R5");
        run_msg();

        // R9: error mid-message, rest discarded, next message restarts at 0
        bp_mode = 1;
        put_str("[1.]");
        expect_tok(T_LBRACK, 0, "R2"); expect_tok(T_ERR, 3, "R9");
        run_msg();
        put_str("[1]");
        expect_tok(T_LBRACK, 0, "R9"); expect_tok(T_INT, 1, "R9");
        expect_tok(T_RBRACK, 2, "R9"); expect_tok(T_EOM, 3, "R9");
        run_msg();

        // R8: trailing whitespace before end of message
        bp_mode = 0;
        put_str("7  ");
        expect_tok(T_INT, 0, "R4"); expect_tok(T_EOM, 3, "R8");
        run_msg();

        // R10: exactly MAXL bytes accepted, one more rejected
        for (int i = 0; i < MAXL; i++) tx.push_back(8'h31);
        expect_tok(T_INT, 0, "R10"); expect_tok(T_EOM, MAXL, "R10");
        run_msg();
        bp_mode = 2;
        for (int i = 0; i < MAXL + 1; i++) tx.push_back(8'h31);
        expect_tok(T_ERR, MAXL, "R10");
        run_msg();
        bp_mode = 0;
        put_str("[]");
        expect_tok(T_LBRACK, 0, "R10"); expect_tok(T_RBRACK, 1, "R10"); expect_tok(T_EOM, 2, "R10");
        run_msg();

        if (wd) check(1'b0, "R1", "watchdog expired", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule